// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block collects event pulses from a set of peripheral sources and turns them into a single interrupt request toward a processor core. Each source has a sticky pending flag, its own enable bit in a mask register, and a shared global enable that gates all sources together. When at least one source is pending, enabled and globally allowed, the block raises a request and presents the handler vector of the winning source.

Source index k maps to vector k+1. Vector 0 is the reset vector. A source whose handler is not installed is steered to vector 0. Requests are offered on a valid/ready pair. The core raises `irq_ready` only at an instruction boundary, after the current instruction has completed. The cycle in which both are high is the acknowledge. An acknowledge clears the winner's pending flag and drops the global enable. A return-from-interrupt pulse sets the global enable again.

Back-pressure rules: `irq_valid` is computed from registered state. It may drop without being accepted, for example when the core clears the global enable or software removes the source's enable bit. `irq_vector` may change while `irq_valid` waits, because a lower-index source can become pending in the meantime. The core must therefore take the vector in the acknowledge cycle. Nothing is lost while `irq_ready` is low, because the pending flags hold their events.

Top module: `vect_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, every pending flag and the global enable are 0, and `irq_valid` is 0.
- R2: A 1 on `src_evt[k]` sets source k's pending flag at the next clock edge. The flag stays set whatever the enable and global-enable values are, until an acknowledge of that source clears it.
- R3: `irq_valid` is 1 exactly when some source is pending, has its enable bit set and the global enable is 1. A cycle with `en_wr`=1 replaces the whole enable mask with `en_wdata` at the next edge.
- R4: An event that arrived while its enable bit was 0 raises `irq_valid` in the cycle after the enable bit is written to 1, provided the global enable is 1.
- R5: When several sources qualify, the source with the lowest index (lowest vector number) is presented.
- R6: The vector of source index k is k+1 on `irq_vector`. The timer compare-A source sits at index 11 and therefore gets vector 12.
- R7: When the winning source has `hdl_ok[k]`=0, `irq_vector` is 0, the reset vector.
- R8: An acknowledge (`irq_valid` and `irq_ready` both 1) clears only the presented source's pending flag. If a new event on that source arrives in the same cycle, the flag stays set.
- R9: An acknowledge clears the global enable at the next edge. This takes priority over `gie_set` and `reti` in the same cycle.
- R10: `gie_set` or `reti` sets the global enable at the next edge, and `gie_clr` clears it. When both kinds arrive in the same cycle, the clear wins. `gie_q` shows the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | N_SRC | Event pulses, one per source |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | N_SRC | New enable mask |
| hdl_ok | input | N_SRC | 1 where a handler is installed for the source |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| reti | input | 1 | Return-from-interrupt pulse; sets the global enable |
| irq_valid | output | 1 | Request toward the core |
| irq_ready | input | 1 | Core is at an instruction boundary and accepts |
| irq_vector | output | VEC_W | Vector of the presented source |
| gie_q | output | 1 | Current global enable |

## Verification
Several properties are checked on every cycle:
- a request is only raised while the global enable is on;
- an acknowledge always drops the global enable;
- at most one source is granted;
- a granted source without a handler always yields vector 0;
- pending flags never vanish without an acknowledge;
- an enable write lands intact.

Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a reference model:
- which source wins, and the exact vector value;
- delivery of an event that arrived while disabled once its enable is written;
- same-cycle collisions between an acknowledge and a new event or a return pulse.

// File: rtl/virq_pkg.sv
package virq_pkg;
  typedef enum logic [1:0] {
    GIE_KEEP = 2'd0,
    GIE_ON   = 2'd1,
    GIE_OFF  = 2'd2
  } gie_act_e;

  // acknowledge beats explicit clear, clear beats set/return
  function automatic gie_act_e gie_decide(input logic ack, input logic clr,
                                          input logic set);
    if (ack || clr) return GIE_OFF;
    if (set)        return GIE_ON;
    return GIE_KEEP;
  endfunction
endpackage

// File: rtl/virq_pend.sv
module virq_pend #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] clr_oh,
  output logic [N_SRC-1:0] pend_q
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        pend_q[k] <= 1'b0;
      else if (evt[k])   pend_q[k] <= 1'b1;
      else if (clr_oh[k]) pend_q[k] <= 1'b0;
    end
  end

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_oh)) == $past(pend_q & ~clr_oh))); // R2
endmodule

// File: rtl/virq_mask.sv
module virq_mask #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_wdata,
  input  logic             ack,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             reti,
  output logic [N_SRC-1:0] en_q,
  output logic             gie_q
);
  import virq_pkg::*;

  gie_act_e act;

  always_comb act = gie_decide(ack, gie_clr, gie_set | reti);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata;
      case (act)
        GIE_ON:  gie_q <= 1'b1;
        GIE_OFF: gie_q <= 1'b0;
        default: gie_q <= gie_q;
      endcase
    end
  end

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(en_wdata))); // R3
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie_q); // R10
endmodule

// File: rtl/virq_arb.sv
module virq_arb #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned VEC_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] hdl_ok,
  output logic             valid,
  output logic [N_SRC-1:0] grant_oh,
  output logic [VEC_W-1:0] vector
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = i[IDX_W-1:0];
    end
    grant_oh = req & (~req + 1'b1);
    valid    = |req;
    if (valid && hdl_ok[idx]) vector = VEC_W'(idx) + VEC_W'(1);
    else                      vector = '0;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($onehot(grant_oh) && ((grant_oh & req) == grant_oh))); // R5
  AST_NOHDL_RESET_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ((grant_oh & ~hdl_ok) != '0)) |-> (vector == '0)); // R7
endmodule

// File: rtl/vect_irq_ctrl.sv
module vect_irq_ctrl #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned VEC_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_wdata,
  input  logic [N_SRC-1:0] hdl_ok,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             reti,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector,
  output logic             gie_q
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] grant_oh;
  logic [N_SRC-1:0] clr_oh;
  logic             ack;

  assign req    = pend_q & en_q & {N_SRC{gie_q}};
  assign ack    = irq_valid & irq_ready;
  assign clr_oh = grant_oh & {N_SRC{ack}};

  virq_pend #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr_oh(clr_oh), .pend_q(pend_q)
  );

  virq_mask #(.N_SRC(N_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .ack(ack),
    .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
    .en_q(en_q), .gie_q(gie_q)
  );

  virq_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .hdl_ok(hdl_ok),
    .valid(irq_valid), .grant_oh(grant_oh), .vector(irq_vector)
  );

  AST_VALID_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> gie_q); // R3
  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !gie_q); // R9
  AST_ACK_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |-> ($countones(clr_oh) == 1)); // R8
endmodule

// File: tb/test_vect_irq_ctrl.sv
module test_vect_irq_ctrl;
  localparam int N = 16;
  localparam int VW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_evt = '0, en_wdata = '0, hdl_ok = '1;
  logic en_wr = 0, gie_set = 0, gie_clr = 0, reti = 0, irq_ready = 0;
  logic irq_valid, gie_q;
  logic [VW-1:0] irq_vector;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [N-1:0] m_pend = '0, m_en = '0;
  logic m_gie = 0;

  always #2 clk = ~clk;

  vect_irq_ctrl #(.N_SRC(N)) i_vect_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .en_wr(en_wr),
    .en_wdata(en_wdata), .hdl_ok(hdl_ok), .gie_set(gie_set),
    .gie_clr(gie_clr), .reti(reti), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector), .gie_q(gie_q)
  );

  function automatic logic [N-1:0] m_req();
    return m_pend & m_en & {N{m_gie}};
  endfunction

  function automatic int m_idx();
    for (int i = 0; i < N; i++) if (m_req()[i]) return i;
    return -1;
  endfunction

  function automatic logic [VW-1:0] m_vec();
    int k = m_idx();
    if (k < 0 || !hdl_ok[k]) return '0;
    return VW'(k + 1);
  endfunction

  task automatic check(input string tag);
    logic ev = (m_idx() >= 0);
    logic [VW-1:0] evec = ev ? m_vec() : '0;
    n_run++;
    if (irq_valid !== ev || irq_vector !== evec || gie_q !== m_gie) begin
      n_fail++;
      $display("FAIL %s: valid/vector/gie actual %b/%0d/%b expected %b/%0d/%b",
               tag, irq_valid, irq_vector, gie_q, ev, evec, m_gie);
    end
  endtask

  task automatic step(input logic [N-1:0] ev, input logic wr, input logic [N-1:0] wd,
                      input logic gs, input logic gc, input logic rt,
                      input logic rdy, input string tag);
    logic ack;
    int k;
    src_evt = ev; en_wr = wr; en_wdata = wd; gie_set = gs; gie_clr = gc;
    reti = rt; irq_ready = rdy;
    k = m_idx();
    ack = (k >= 0) && rdy;
    if (ack) m_pend[k] = 1'b0;
    m_pend = m_pend | ev;
    if (wr) m_en = wd;
    if (ack || gc) m_gie = 1'b0;
    else if (gs || rt) m_gie = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1 check("R1 in reset");
    rst_n = 1'b1;
    step('0, 0, '0, 0, 0, 0, 0, "R1 after reset");
    // events with gie on but no enable: held, no request
    step(16'h0808, 0, '0, 1, 0, 0, 1, "R2 R3 masked by enables");
    step('0, 0, '0, 0, 0, 0, 1, "R2 held");
    // enable only index 11: delivered next cycle, vector 12
    step('0, 1, 16'h0800, 0, 0, 0, 0, "R4 R6 late enable vector 12");
    step('0, 1, 16'h0808, 0, 0, 0, 0, "R5 lowest index wins");
    hdl_ok = 16'hFFF7;
    #1 check("R7 no handler -> vector 0");
    hdl_ok = '1;
    #1 check("R6 vector 4");
    // acknowledge: clears index 3 only and drops gie
    step('0, 0, '0, 0, 0, 0, 1, "R8 R9 ack");
    step('0, 0, '0, 0, 0, 1, 0, "R10 reti re-arms, index 11 left");
    // ack together with new event on same source: stays pending
    step(16'h0800, 0, '0, 0, 0, 1, 1, "R8 R9 ack vs event and reti");
    step('0, 0, '0, 1, 0, 0, 0, "R8 still pending");
    step('0, 0, '0, 1, 1, 0, 0, "R10 clear beats set");
    step('0, 0, '0, 0, 0, 1, 0, "R10 reti sets");
    step('0, 1, 16'h0000, 0, 0, 0, 0, "R3 mask removed drops valid");
    step('0, 1, 16'hFFFF, 0, 0, 0, 0, "R3 mask restored");
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] ev = ($urandom % 6 == 0) ? (N'(1) << ($urandom % N)) : '0;
      logic wr = ($urandom % 25 == 0);
      logic [N-1:0] wd = N'($urandom);
      if ($urandom % 60 == 0) hdl_ok = N'($urandom) | N'($urandom);
      step(ev, wr, wd, ($urandom % 7 == 0), ($urandom % 40 == 0),
           ($urandom % 9 == 0), ($urandom % 3 == 0), "R3 R5 R8 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule